// File: doc/BRIEF.md
# Serial Sampling Converter Sequencer with Automatic Sleep

This block is the digital control side of a serial sampling analog-to-digital converter. It watches an active-low chip select, a frame-sync strobe and a serial clock. From these it opens a frame, counts the sample window in serial-clock falling edges and shifts the previous result out MSB first. It then runs a conversion lasting a fixed number of ticks of a separate internal oscillator and stores the new result. The analog core is stood in for by a parallel input word, which is captured on the last conversion tick.

Two ways to start a frame are supported, chosen by a mode input. In chip-select mode, the falling edge of chip select opens the frame and also presents the stored MSB. In frame-sync mode, chip select may be held low. A rising frame sync presents the MSB, and a falling frame sync seen while the serial clock is high opens the frame. Releasing the controlling strobe before the conversion has finished cancels the frame, pulses an error and marks the stored data as stale. Power is shown as a state output. The block sleeps as soon as a frame ends, drops into a deeper sleep after a programmable count of system clocks without activity, and wakes on a chip-select fall or a frame-sync rise.

All inputs are taken to be synchronous to the system clock. Edges are found by comparing each input with its value at the previous system clock.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset, pwr_state is 2'd1 (sleep), and busy, sdo, conv_done, abort_err and data_invalid are all 0.
- R2: With mode_fs=0 and the block idle, a falling cs_n sets busy and pwr_state 2'd0 (awake) one clock later, and sdo then shows bit 11 of the stored result.
- R3: With mode_fs=1 and the block idle, a falling fs starts a frame only if sclk is 1 in that clock; with sclk at 0 busy stays 0.
- R4: With mode_fs=1 and the block idle, a rising fs or a falling cs_n loads the stored result, so sdo shows its bit 11 one clock later.
- R5: During the sample window each sclk falling edge shifts sdo to the next lower result bit; after the 12 data bits sdo reads 0, and the 16th falling edge ends the window.
- R6: The conversion ends on exactly the 14th osc_tick clock after the sample window: conv_done pulses for one clock, busy drops and conv_word becomes the stored result; after 13 ticks busy is still 1.
- R7: A rising cs_n (mode_fs=0) or rising fs (mode_fs=1) before the conversion ends cancels the frame: abort_err pulses, busy drops, data_invalid becomes 1, and the stored result is left as it was; the next completed conversion clears data_invalid.
- R8: pwr_state reads 2'd1 (sleep) in the same clock in which conv_done or abort_err is 1.
- R9: pwr_state moves from 2'd1 to 2'd2 (deep sleep) after DEEP_CYCLES system clocks with no wake event, and not one clock earlier.
- R10: While idle, a cs_n fall or an fs rise returns pwr_state to 2'd0 one clock later, from either sleep level; pwr_state is 2'd0 whenever busy is 1.
- R11: sdo_oe is 0 whenever cs_n is 1 and 1 whenever cs_n is 0.
- R12: osc_tick clocks during the sample window and sclk edges during the conversion have no effect on the frame timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_fs | input | 1 | 0: chip-select start, 1: frame-sync start |
| cs_n | input | 1 | Active-low chip select |
| fs | input | 1 | Frame sync strobe |
| sclk | input | 1 | Serial clock level |
| osc_tick | input | 1 | One-clock pulse per internal oscillator tick |
| conv_word | input | RES_W | Result presented by the converter core |
| sdo | output | 1 | Serial data out, MSB first |
| sdo_oe | output | 1 | Output enable for sdo (0 means high impedance) |
| busy | output | 1 | Frame in progress (sample or conversion) |
| conv_done | output | 1 | One-clock pulse when a conversion completes |
| abort_err | output | 1 | One-clock pulse when a frame is cancelled |
| data_invalid | output | 1 | Stored result came from a cancelled frame |
| pwr_state | output | 2 | 0 awake, 1 sleep, 2 deep sleep |

## Verification
A wrong sample counter shows up at the ports within one serial clock, as a misplaced bit on sdo. It also shows up at the end of the window, as conv_done arriving a tick early or late. A stuck phase state shows up within one clock of a strobe release, as a missing abort_err or a busy that never drops. A wrong inactivity counter moves the deep-sleep step of pwr_state by at least one clock; the bench samples pwr_state on both sides of the expected clock, so an off-by-one is caught. A missed wake event leaves pwr_state at a sleep value one clock after the cs_n fall or fs rise.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SAMPLE = 2'd1,
        SEQ_CONV   = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        PWR_ACTIVE = 2'd0,
        PWR_DOWN   = 2'd1,
        PWR_DEEP   = 2'd2
    } pwr_e;

endpackage

// File: rtl/adc_seq_history.sv
// Holds the previous system-clock level of each watched input so that
// edges can be found by comparison with the present level.
module adc_seq_history #(
    parameter int               N       = 3,
    parameter logic [N-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] prev
);
    typedef struct packed {
        logic [N-1:0] lvl;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        for (int i = 0; i < N; i++) begin
            hist_d.lvl[i] = lvl[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q.lvl <= RST_VAL;
        end else begin
            hist_q <= hist_d;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_prev
        assign prev[g] = hist_q.lvl[g];
    end
endmodule

// File: rtl/adc_seq_shift.sv
// Output shifter: a load places the result in the top bits of a frame-wide
// register, and each shift moves it left by one, filling with zero.
module adc_seq_shift #(
    parameter int RES_W   = 12,
    parameter int FRAME_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [RES_W-1:0] din,
    output logic             sdo
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load) begin
            shf_d.sr = '0;
            shf_d.sr[FRAME_W-1 -: RES_W] = din;
        end else if (shift) begin
            shf_d.sr = {shf_q.sr[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shf_q.sr <= '0;
        end else begin
            shf_q <= shf_d;
        end
    end

    assign sdo = shf_q.sr[FRAME_W-1];
endmodule

// File: rtl/adc_seq_pwr.sv
// Power level tracker: wake wins, sleep restarts the inactivity count,
// and a full count in light sleep moves to deep sleep.
module adc_seq_pwr
    import adc_seq_pkg::*;
#(
    parameter int DEEP_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake,
    input  logic sleep,
    output pwr_e level
);
    localparam int CW = $clog2(DEEP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEEP_CYCLES - 1);

    typedef struct packed {
        pwr_e          st;
        logic [CW-1:0] cnt;
    } pwr_t;

    pwr_t pwr_d, pwr_q;

    always_comb begin
        pwr_d = pwr_q;
        if (wake) begin
            pwr_d.st  = PWR_ACTIVE;
            pwr_d.cnt = '0;
        end else if (sleep) begin
            pwr_d.st  = PWR_DOWN;
            pwr_d.cnt = '0;
        end else if (pwr_q.st == PWR_DOWN) begin
            if (pwr_q.cnt == LAST) begin
                pwr_d.st = PWR_DEEP;
            end else begin
                pwr_d.cnt = pwr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q.st  <= PWR_DOWN;
            pwr_q.cnt <= '0;
        end else begin
            pwr_q <= pwr_d;
        end
    end

    assign level = pwr_q.st;
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int FRAME_CLKS  = 16,
    parameter int CONV_TICKS  = 14,
    parameter int DEEP_CYCLES = 250000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_fs,
    input  logic             cs_n,
    input  logic             fs,
    input  logic             sclk,
    input  logic             osc_tick,
    input  logic [RES_W-1:0] conv_word,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             busy,
    output logic             conv_done,
    output logic             abort_err,
    output logic             data_invalid,
    output logic [1:0]       pwr_state
);
    localparam int FCW = $clog2(FRAME_CLKS + 1);
    localparam int TCW = $clog2(CONV_TICKS + 1);
    localparam logic [FCW-1:0] F_LAST = FCW'(FRAME_CLKS - 1);
    localparam logic [TCW-1:0] T_LAST = TCW'(CONV_TICKS - 1);
    localparam int IDX_CS = 0;
    localparam int IDX_FS = 1;
    localparam int IDX_SC = 2;

    typedef struct packed {
        seq_e             st;
        logic [FCW-1:0]   fcnt;
        logic [TCW-1:0]   tcnt;
        logic [RES_W-1:0] result;
        logic             invalid;
        logic             done;
        logic             abort;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [2:0] lvl, prev;
    logic cs_fall, cs_rise, fs_rise, fs_fall, sc_fall;
    logic start_ev, release_ev, load_ev, shift_ev, wake_ev, sleep_ev;
    pwr_e level;

    assign lvl = {sclk, fs, cs_n};

    adc_seq_history #(
        .N       (3),
        .RST_VAL (3'b001)
    ) i_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .prev  (prev)
    );

    assign cs_fall = prev[IDX_CS] & ~cs_n;
    assign cs_rise = ~prev[IDX_CS] & cs_n;
    assign fs_rise = ~prev[IDX_FS] & fs;
    assign fs_fall = prev[IDX_FS] & ~fs;
    assign sc_fall = prev[IDX_SC] & ~sclk;

    // Start and release depend on the selected start method.
    assign start_ev   = mode_fs ? (fs_fall & sclk) : cs_fall;
    assign release_ev = mode_fs ? fs_rise : cs_rise;

    always_comb begin
        seq_d       = seq_q;
        seq_d.done  = 1'b0;
        seq_d.abort = 1'b0;
        load_ev     = 1'b0;
        shift_ev    = 1'b0;
        wake_ev     = 1'b0;
        sleep_ev    = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                load_ev = mode_fs ? (cs_fall | fs_rise) : cs_fall;
                wake_ev = cs_fall | fs_rise | start_ev;
                if (start_ev) begin
                    seq_d.st   = SEQ_SAMPLE;
                    seq_d.fcnt = '0;
                end
            end
            SEQ_SAMPLE: begin
                if (release_ev) begin
                    seq_d.st      = SEQ_IDLE;
                    seq_d.abort   = 1'b1;
                    seq_d.invalid = 1'b1;
                    sleep_ev      = 1'b1;
                end else if (sc_fall) begin
                    shift_ev = 1'b1;
                    if (seq_q.fcnt == F_LAST) begin
                        seq_d.st   = SEQ_CONV;
                        seq_d.tcnt = '0;
                    end else begin
                        seq_d.fcnt = seq_q.fcnt + 1'b1;
                    end
                end
            end
            SEQ_CONV: begin
                if (release_ev) begin
                    seq_d.st      = SEQ_IDLE;
                    seq_d.abort   = 1'b1;
                    seq_d.invalid = 1'b1;
                    sleep_ev      = 1'b1;
                end else if (osc_tick) begin
                    if (seq_q.tcnt == T_LAST) begin
                        seq_d.st      = SEQ_IDLE;
                        seq_d.result  = conv_word;
                        seq_d.invalid = 1'b0;
                        seq_d.done    = 1'b1;
                        sleep_ev      = 1'b1;
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st      <= SEQ_IDLE;
            seq_q.fcnt    <= '0;
            seq_q.tcnt    <= '0;
            seq_q.result  <= '0;
            seq_q.invalid <= 1'b0;
            seq_q.done    <= 1'b0;
            seq_q.abort   <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    adc_seq_shift #(
        .RES_W   (RES_W),
        .FRAME_W (FRAME_CLKS)
    ) i_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_ev),
        .shift (shift_ev),
        .din   (seq_q.result),
        .sdo   (sdo)
    );

    adc_seq_pwr #(
        .DEEP_CYCLES (DEEP_CYCLES)
    ) i_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .wake  (wake_ev),
        .sleep (sleep_ev),
        .level (level)
    );

    assign sdo_oe       = ~cs_n;
    assign busy         = (seq_q.st != SEQ_IDLE);
    assign conv_done    = seq_q.done;
    assign abort_err    = seq_q.abort;
    assign data_invalid = seq_q.invalid;
    assign pwr_state    = level;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_fs,
    input logic       cs_n,
    input logic       fs,
    input logic       sclk,
    input logic       busy,
    input logic       conv_done,
    input logic       abort_err,
    input logic       data_invalid,
    input logic [1:0] pwr_state
);
    AST_CS_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_fs && $fell(cs_n) && !busy) |=> busy); // R2

    AST_FS_LOW_CLOCK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fs && $fell(fs) && !sclk && !busy) |=> !busy); // R3

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done); // R6

    AST_ABORT_MARKS_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |-> (data_invalid && !busy)); // R7

    AST_END_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done || abort_err) |-> (pwr_state == 2'd1)); // R8

    AST_DEEP_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 2'd2 && $past(pwr_state) != 2'd2) |-> ($past(pwr_state) == 2'd1)); // R9

    AST_BUSY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pwr_state == 2'd0)); // R10
endmodule

bind adc_serial_seq adc_seq_checker i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_fs      (mode_fs),
    .cs_n         (cs_n),
    .fs           (fs),
    .sclk         (sclk),
    .busy         (busy),
    .conv_done    (conv_done),
    .abort_err    (abort_err),
    .data_invalid (data_invalid),
    .pwr_state    (pwr_state)
);

// File: tb/test_adc_serial_seq.sv
module test_adc_serial_seq;
    localparam int RES_W = 12;
    localparam int FRAME = 16;
    localparam int TICKS = 14;
    localparam int DEEP  = 50;
    localparam logic [1:0] P_ACT  = 2'd0;
    localparam logic [1:0] P_DOWN = 2'd1;
    localparam logic [1:0] P_DEEP = 2'd2;

    // {mode_fs, conv_word}
    localparam logic [12:0] VEC [6] = '{
        {1'b0, 12'hA5C}, {1'b1, 12'h3C1}, {1'b0, 12'hFFF},
        {1'b1, 12'h001}, {1'b0, 12'h800}, {1'b1, 12'h7FE}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_fs = 1'b0, cs_n = 1'b1, fs = 1'b0, sclk = 1'b0, osc_tick = 1'b0;
    logic [RES_W-1:0] conv_word = '0;
    logic sdo, sdo_oe, busy, conv_done, abort_err, data_invalid;
    logic [1:0] pwr_state;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    logic [RES_W-1:0] shown = '0;

    always #4 clk = ~clk;

    adc_serial_seq #(
        .RES_W(RES_W), .FRAME_CLKS(FRAME), .CONV_TICKS(TICKS), .DEEP_CYCLES(DEEP)
    ) i_adc_serial_seq (
        .clk(clk), .rst_n(rst_n), .mode_fs(mode_fs), .cs_n(cs_n), .fs(fs),
        .sclk(sclk), .osc_tick(osc_tick), .conv_word(conv_word), .sdo(sdo),
        .sdo_oe(sdo_oe), .busy(busy), .conv_done(conv_done), .abort_err(abort_err),
        .data_invalid(data_invalid), .pwr_state(pwr_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sclk_fall();
        if (sclk == 1'b0) begin
            sclk = 1'b1;
            step();
        end
        sclk = 1'b0;
        step();
    endtask

    task automatic open_frame(input bit m);
        mode_fs = m;
        if (!m) begin
            if (cs_n == 1'b0) begin
                cs_n = 1'b1;
                step();
            end
            cs_n = 1'b0;
            step();
            chk("R2 busy after cs fall", busy, 1);
            chk("R2 msb on sdo", sdo, shown[RES_W-1]);
            chk("R10 awake", pwr_state, P_ACT);
            chk("R11 oe low cs", sdo_oe, 1);
        end else begin
            cs_n = 1'b0;
            fs   = 1'b1;
            step();
            chk("R4 msb after fs rise", sdo, shown[RES_W-1]);
            chk("R4 not busy yet", busy, 0);
            chk("R10 awake on fs rise", pwr_state, P_ACT);
            sclk = 1'b1;
            step();
            fs = 1'b0;
            step();
            chk("R3 start with sclk high", busy, 1);
        end
    endtask

    task automatic frame_body(input bit noise, input logic [RES_W-1:0] nw);
        for (int i = 0; i < FRAME; i++) begin
            chk("R5 serial bit", sdo, (i < RES_W) ? shown[RES_W-1-i] : 1'b0);
            chk("R5 busy in window", busy, 1);
            osc_tick = noise;
            sclk_fall();
            osc_tick = 1'b0;
        end
        conv_word = nw;
        for (int t = 0; t < TICKS; t++) begin
            osc_tick = 1'b1;
            if (noise) sclk = ~sclk;
            step();
            osc_tick = 1'b0;
            if (t < TICKS - 1) begin
                chk("R6 still converting", busy, 1);
                chk("R6 no early done", conv_done, 0);
            end else begin
                chk("R6 done pulse", conv_done, 1);
                chk("R6 busy drops", busy, 0);
                chk("R8 sleep at done", pwr_state, P_DOWN);
                chk("R7 invalid cleared", data_invalid, 0);
            end
        end
        if (noise) chk("R12 noise ignored done", conv_done, 1);
        shown = nw;
        step();
        chk("R6 done one clock", conv_done, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 pwr", pwr_state, P_DOWN);
        chk("R1 busy", busy, 0);
        chk("R1 sdo", sdo, 0);
        chk("R1 done", conv_done, 0);
        chk("R1 abort", abort_err, 0);
        chk("R1 invalid", data_invalid, 0);
        chk("R11 oe cs high", sdo_oe, 0);

        foreach (VEC[k]) begin
            open_frame(VEC[k][12]);
            frame_body(k == 2, VEC[k][11:0]);
            if (!VEC[k][12]) begin
                cs_n = 1'b1;
                step();
                chk("R11 oe off", sdo_oe, 0);
            end
        end

        // R3: fs fall with sclk low does not start
        mode_fs = 1'b1;
        sclk = 1'b0;
        fs = 1'b1;
        step();
        fs = 1'b0;
        step();
        chk("R3 no start sclk low", busy, 0);

        // R7: abort in the sample window, chip-select mode
        open_frame(0);
        repeat (3) sclk_fall();
        cs_n = 1'b1;
        step();
        chk("R7 abort pulse", abort_err, 1);
        chk("R7 busy drops", busy, 0);
        chk("R7 invalid set", data_invalid, 1);
        chk("R8 sleep at abort", pwr_state, P_DOWN);
        step();
        chk("R7 abort one clock", abort_err, 0);
        open_frame(0);   // stored result unchanged: checks MSB of shown
        frame_body(0, 12'h5A3);
        cs_n = 1'b1;
        step();

        // R7: abort during conversion, frame-sync mode
        open_frame(1);
        repeat (FRAME) sclk_fall();
        repeat (5) begin
            osc_tick = 1'b1;
            step();
            osc_tick = 1'b0;
        end
        chk("R6 converting after 5", busy, 1);
        fs = 1'b1;
        step();
        chk("R7 abort in conv", abort_err, 1);
        chk("R7 invalid conv abort", data_invalid, 1);
        chk("R8 sleep not wake", pwr_state, P_DOWN);
        fs = 1'b0;
        step();

        // R9: deep sleep timing
        repeat (DEEP - 2) step();
        chk("R9 not yet deep", pwr_state, P_DOWN);
        step();
        chk("R9 deep", pwr_state, P_DEEP);
        repeat (5) step();
        chk("R9 stays deep", pwr_state, P_DEEP);

        // R10: wake from deep sleep on fs rise
        fs = 1'b1;
        step();
        chk("R10 wake from deep", pwr_state, P_ACT);
        chk("R10 no frame", busy, 0);
        chk("R7 result kept", sdo, shown[RES_W-1]);
        fs = 1'b0;
        step();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule